// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decoder

This block is a test access port controller in the style of IEEE 1149.1. A 16-state machine runs on the test clock and is steered by the mode-select input. A 4-bit instruction register picks one of three data paths: a 32-bit identification register, a single-bit bypass stage, or a parameterised chain of boundary cells. Each boundary cell has a shift stage and an update stage. The same instruction also drives four control outputs toward the rest of the chip: a pin-mode code, a functional-reset request, an enable for the flash programming port, and a flag that hands the scan path to an external debug controller.

The machine uses the usual sixteen states. Test-Logic-Reset goes to Run-Test/Idle when mode-select is 0. The two column states, Select-DR-Scan and Select-IR-Scan, lead to Capture. Capture leads to Shift. Shift, Exit1, Pause and Exit2 form the shift/pause loop. Exit1 or Exit2 leads to Update. Update returns to Run-Test/Idle or to Select-DR-Scan. Select-IR-Scan goes back to Test-Logic-Reset when mode-select is 1. Capture, shift and update actions take place on the rising test-clock edge that leaves the named state. Serial output changes on the falling edge.

Top module: `scan_tap_ctrl`

## Requirements
- R1: An asynchronous low on `trst_n` puts the machine in Test-Logic-Reset, clears the boundary update stage and all control outputs. Five rising edges with `tms` high also reach Test-Logic-Reset from any state, and four are not enough from Shift-DR. Leaving Test-Logic-Reset leaves the instruction at 0000, so the identification register is selected.
- R2: In Capture-IR the instruction shift stage loads 0001. Shifting moves bits LSB first, so the first bit on `tdo` is 1 and the next three are 0.
- R3: A new instruction, together with its control outputs, takes effect only on the edge that leaves Update-IR. Outputs keep their old values through Shift-IR, Exit1-IR and Update-IR, and overrides persist until another instruction is updated.
- R4: Opcode 0000 selects the 32-bit identification register. It captures `ID_VALUE` with bit 0 forced to 1.
- R5: Opcode 1111, the reserved codes 0101/0110/0111 and every other unlisted code select a 1-bit bypass stage that captures 0. For these codes pin mode is 00 and the reset, flash and forward outputs stay low.
- R6: Opcodes 0010 and 0011 select the boundary chain with pin mode 00 (functional) and no reset. Only 0010 copies the shift stage into the update stage on Update-DR. Under 0011 `bsr_upd` is unchanged.
- R7: Opcode 0100 selects the boundary chain, sets pin mode 01 (drive update-stage values) and raises `func_reset`. Update-DR loads the update stage under this opcode.
- R8: Opcode 1001 selects bypass, sets pin mode 10 (high impedance) and raises `func_reset`.
- R9: Opcode 1100 selects bypass, sets pin mode 01 and raises `func_reset`.
- R10: Opcode 1101 selects bypass and raises both `flash_port_en` and `func_reset`, with pin mode 00.
- R11: Opcodes 1000, 1010, 1011 and 1110 raise `dbg_forward` and select bypass locally, without reset or pin override.
- R12: `tdo` changes only on the falling edge of `tck`. `tdo_en` is high only while the state is Shift-IR or Shift-DR.
- R13: When the boundary chain is selected, Capture-DR loads `bsr_cap_in` into the shift stage. Bit 0 is shifted out first and `tdi` enters at bit `NPINS-1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| bsr_cap_in | input | NPINS | Pin values captured into the boundary chain |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | High while shifting IR or DR |
| bsr_upd | output | NPINS | Boundary update-stage values |
| pin_mode | output | 2 | 00 functional, 01 drive update stage, 10 high impedance |
| func_reset | output | 1 | Functional reset request |
| flash_port_en | output | 1 | Flash programming port enable |
| dbg_forward | output | 1 | Scan path handed to the external debug controller |

## Verification
Pin override and boundary update can act in the same cycle. With opcode 0100 active, pin mode 01 is already driving the update stage onto the pins, and an Update-DR then replaces those values on the same edge. The bench first preloads a pattern under 0010 and switches to 0100, checking that the preloaded pattern is what gets driven. It then scans a new pattern and checks that, right after Update-DR, `bsr_upd` holds the new value while `pin_mode` and `func_reset` keep their override values. A second overlap comes from the five-edge mode-select reset landing while an override instruction is active: the bench checks that the override survives four edges and is dropped only once the machine has left Test-Logic-Reset.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        PM_FUNC  = 2'b00,
        PM_DRIVE = 2'b01,
        PM_FLOAT = 2'b10
    } pin_mode_e;

    typedef enum logic [1:0] {
        DR_IDENT = 2'd0,
        DR_BYP   = 2'd1,
        DR_CHAIN = 2'd2
    } dr_sel_e;

    typedef struct packed {
        dr_sel_e   dr;
        pin_mode_e pmode;
        logic      func_rst;
        logic      flash_en;
        logic      fwd;
        logic      upd_ok;
    } ir_ctrl_t;

    localparam logic [IR_W-1:0] OP_IDENT      = 4'b0000;
    localparam logic [IR_W-1:0] OP_SNAP_LOAD  = 4'b0010;
    localparam logic [IR_W-1:0] OP_SNAP       = 4'b0011;
    localparam logic [IR_W-1:0] OP_PIN_DRIVE  = 4'b0100;
    localparam logic [IR_W-1:0] OP_FWD_A      = 4'b1000;
    localparam logic [IR_W-1:0] OP_PIN_FLOAT  = 4'b1001;
    localparam logic [IR_W-1:0] OP_FWD_B      = 4'b1010;
    localparam logic [IR_W-1:0] OP_FWD_C      = 4'b1011;
    localparam logic [IR_W-1:0] OP_PIN_HOLD   = 4'b1100;
    localparam logic [IR_W-1:0] OP_FLASH_PORT = 4'b1101;
    localparam logic [IR_W-1:0] OP_FWD_D      = 4'b1110;
    localparam logic [IR_W-1:0] OP_BYPASS     = 4'b1111;

    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 4'b0001;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output logic       in_reset,
    output logic       cap_ir,
    output logic       shf_ir,
    output logic       upd_ir,
    output logic       cap_dr,
    output logic       shf_dr,
    output logic       upd_dr
);

    tap_state_e nxt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

    always_comb begin
        unique case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // Action strobes: each acts on the rising edge that leaves the state.
    always_comb begin
        in_reset = (state == ST_RESET);
        cap_ir   = (state == ST_CAP_IR);
        shf_ir   = (state == ST_SHF_IR);
        upd_ir   = (state == ST_UPD_IR);
        cap_dr   = (state == ST_CAP_DR);
        shf_dr   = (state == ST_SHF_DR);
        upd_dr   = (state == ST_UPD_DR);
    end

    // R1: five consecutive high mode-select samples always land in reset.
    assert_tms5_reset_R1: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
        |-> (state == ST_RESET));

endmodule

// File: rtl/tap_ir_decode.sv
module tap_ir_decode
    import scan_tap_pkg::*;
(
    input  logic [IR_W-1:0] ir,
    output ir_ctrl_t        ctrl
);

    always_comb begin
        ctrl = '{dr: DR_BYP, pmode: PM_FUNC, func_rst: 1'b0,
                 flash_en: 1'b0, fwd: 1'b0, upd_ok: 1'b0};
        unique case (ir)
            OP_IDENT:      ctrl.dr = DR_IDENT;
            OP_SNAP_LOAD: begin
                ctrl.dr     = DR_CHAIN;
                ctrl.upd_ok = 1'b1;
            end
            OP_SNAP:       ctrl.dr = DR_CHAIN;
            OP_PIN_DRIVE: begin
                ctrl.dr       = DR_CHAIN;
                ctrl.upd_ok   = 1'b1;
                ctrl.pmode    = PM_DRIVE;
                ctrl.func_rst = 1'b1;
            end
            OP_PIN_FLOAT: begin
                ctrl.pmode    = PM_FLOAT;
                ctrl.func_rst = 1'b1;
            end
            OP_PIN_HOLD: begin
                ctrl.pmode    = PM_DRIVE;
                ctrl.func_rst = 1'b1;
            end
            OP_FLASH_PORT: begin
                ctrl.flash_en = 1'b1;
                ctrl.func_rst = 1'b1;
            end
            OP_FWD_A, OP_FWD_B, OP_FWD_C, OP_FWD_D: ctrl.fwd = 1'b1;
            default: ;
        endcase
    end

    // R7: a pin override never comes without a functional reset request.
    always_comb begin
        if (ctrl.pmode != PM_FUNC)
            assert_override_has_reset_R7: assert (ctrl.func_rst);
    end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
    parameter int NPINS = 8
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             cap_en,
    input  logic             shf_en,
    input  logic             upd_en,
    input  logic             tdi,
    input  logic [NPINS-1:0] cap_in,
    output logic             so,
    output logic [NPINS-1:0] upd_q
);

    logic [NPINS-1:0] sh_q;
    logic [NPINS-1:0] sh_src;

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_cell
            if (i == NPINS - 1) begin : g_head
                assign sh_src[i] = tdi;
            end else begin : g_body
                assign sh_src[i] = sh_q[i+1];
            end

            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n) begin
                    sh_q[i]  <= 1'b0;
                    upd_q[i] <= 1'b0;
                end else begin
                    if (cap_en)      sh_q[i] <= cap_in[i];
                    else if (shf_en) sh_q[i] <= sh_src[i];
                    if (upd_en)      upd_q[i] <= sh_q[i];
                end
            end
        end
    endgenerate

    assign so = sh_q[0];

    // R6: update stage moves only on an enabled update edge.
    assert_upd_hold_R6: assert property (@(posedge tck) disable iff (!trst_n)
        !$past(upd_en) |-> $stable(upd_q));

endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
    import scan_tap_pkg::*;
#(
    parameter int          NPINS    = 8,
    parameter logic [31:0] ID_VALUE = 32'h0C3A_5E92
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [NPINS-1:0] bsr_cap_in,
    output logic             tdo,
    output logic             tdo_en,
    output logic [NPINS-1:0] bsr_upd,
    output logic [1:0]       pin_mode,
    output logic             func_reset,
    output logic             flash_port_en,
    output logic             dbg_forward
);

    localparam int          ID_W   = 32;
    localparam logic [ID_W-1:0] ID_EFF = {ID_VALUE[ID_W-1:1], 1'b1};

    tap_state_e      state;
    logic            in_reset, cap_ir, shf_ir, upd_ir, cap_dr, shf_dr, upd_dr;
    logic [IR_W-1:0] ir_q, ir_sh;
    logic [ID_W-1:0] id_sh;
    logic            byp_q;
    logic            chain_so;
    logic            dr_bit;
    ir_ctrl_t        ctrl;

    tap_fsm u_fsm (
        .tck      (tck),
        .trst_n   (trst_n),
        .tms      (tms),
        .state    (state),
        .in_reset (in_reset),
        .cap_ir   (cap_ir),
        .shf_ir   (shf_ir),
        .upd_ir   (upd_ir),
        .cap_dr   (cap_dr),
        .shf_dr   (shf_dr),
        .upd_dr   (upd_dr)
    );

    tap_ir_decode u_dec (
        .ir   (ir_q),
        .ctrl (ctrl)
    );

    bscan_chain #(.NPINS(NPINS)) u_chain (
        .tck    (tck),
        .trst_n (trst_n),
        .cap_en (cap_dr && ctrl.dr == DR_CHAIN),
        .shf_en (shf_dr && ctrl.dr == DR_CHAIN),
        .upd_en (upd_dr && ctrl.upd_ok),
        .tdi    (tdi),
        .cap_in (bsr_cap_in),
        .so     (chain_so),
        .upd_q  (bsr_upd)
    );

    // Instruction path: shift stage and current instruction.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sh <= IR_CAPTURE_PAT;
            ir_q  <= OP_IDENT;
        end else begin
            if (cap_ir)      ir_sh <= IR_CAPTURE_PAT;
            else if (shf_ir) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            if (in_reset)    ir_q  <= OP_IDENT;
            else if (upd_ir) ir_q  <= ir_sh;
        end
    end

    // Identification and bypass data registers.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            id_sh <= ID_EFF;
            byp_q <= 1'b0;
        end else begin
            if (ctrl.dr == DR_IDENT) begin
                if (cap_dr)      id_sh <= ID_EFF;
                else if (shf_dr) id_sh <= {tdi, id_sh[ID_W-1:1]};
            end
            if (ctrl.dr == DR_BYP) begin
                if (cap_dr)      byp_q <= 1'b0;
                else if (shf_dr) byp_q <= tdi;
            end
        end
    end

    always_comb begin
        unique case (ctrl.dr)
            DR_IDENT: dr_bit = id_sh[0];
            DR_CHAIN: dr_bit = chain_so;
            default:  dr_bit = byp_q;
        endcase
    end

    // Serial output, retimed to the falling edge.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= shf_ir || shf_dr;
            tdo    <= shf_ir ? ir_sh[0] : (shf_dr ? dr_bit : 1'b0);
        end
    end

    assign pin_mode      = ctrl.pmode;
    assign func_reset    = ctrl.func_rst;
    assign flash_port_en = ctrl.flash_en;
    assign dbg_forward   = ctrl.fwd;

    // R2: capture loads the fixed pattern into the instruction shift stage.
    assert_ir_capture_R2: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(state) == ST_CAP_IR) |-> (ir_sh == IR_CAPTURE_PAT));

    // R3: instruction changes only via Update-IR or reset.
    assert_ir_update_only_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (ir_q != $past(ir_q)) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_RESET));

    // R1: leaving reset always leaves the identification instruction.
    assert_reset_ident_R1: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(state) == ST_RESET) |-> (ir_q == OP_IDENT));

    // R5: bypass stage captures zero.
    assert_bypass_capture_R5: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(state) == ST_CAP_DR && $past(ctrl.dr) == DR_BYP) |-> !byp_q);

    // R12: output enable only during a shift state.
    assert_tdo_en_shift_R12: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state == ST_SHF_IR || state == ST_SHF_DR));

endmodule

// File: tb/scan_tap_ctrl_test.sv
`timescale 1ns/1ps
module scan_tap_ctrl_test;

    localparam int          NPINS  = 8;
    localparam logic [31:0] ID_EXP = 32'h0C3A_5E93;
    localparam logic [7:0]  CAP    = 8'hA6;

    // {opcode[3:0], dr kind[1:0] (0 ident,1 bypass,2 chain), pin mode[1:0], reset, flash, forward}
    localparam logic [10:0] VEC [16] = '{
        {4'b0000, 2'd0, 2'b00, 1'b0, 1'b0, 1'b0},
        {4'b0001, 2'd1, 2'b00, 1'b0, 1'b0, 1'b0},
        {4'b0010, 2'd2, 2'b00, 1'b0, 1'b0, 1'b0},
        {4'b0011, 2'd2, 2'b00, 1'b0, 1'b0, 1'b0},
        {4'b0100, 2'd2, 2'b01, 1'b1, 1'b0, 1'b0},
        {4'b0101, 2'd1, 2'b00, 1'b0, 1'b0, 1'b0},
        {4'b0110, 2'd1, 2'b00, 1'b0, 1'b0, 1'b0},
        {4'b0111, 2'd1, 2'b00, 1'b0, 1'b0, 1'b0},
        {4'b1000, 2'd1, 2'b00, 1'b0, 1'b0, 1'b1},
        {4'b1001, 2'd1, 2'b10, 1'b1, 1'b0, 1'b0},
        {4'b1010, 2'd1, 2'b00, 1'b0, 1'b0, 1'b1},
        {4'b1011, 2'd1, 2'b00, 1'b0, 1'b0, 1'b1},
        {4'b1100, 2'd1, 2'b01, 1'b1, 1'b0, 1'b0},
        {4'b1101, 2'd1, 2'b00, 1'b1, 1'b1, 1'b0},
        {4'b1110, 2'd1, 2'b00, 1'b0, 1'b0, 1'b1},
        {4'b1111, 2'd1, 2'b00, 1'b0, 1'b0, 1'b0}
    };

    logic             tck = 1'b0;
    logic             trst_n = 1'b0;
    logic             tms = 1'b1;
    logic             tdi = 1'b0;
    logic [NPINS-1:0] bsr_cap_in = CAP;
    logic             tdo, tdo_en, func_reset, flash_port_en, dbg_forward;
    logic [NPINS-1:0] bsr_upd;
    logic [1:0]       pin_mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 tck = ~tck;

    scan_tap_ctrl #(.NPINS(NPINS), .ID_VALUE(32'h0C3A_5E92)) uut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_cap_in(bsr_cap_in),
        .tdo(tdo), .tdo_en(tdo_en), .bsr_upd(bsr_upd), .pin_mode(pin_mode),
        .func_reset(func_reset), .flash_port_en(flash_port_en), .dbg_forward(dbg_forward)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    // From Run-Test/Idle to Update-IR with the opcode shifted in.
    task automatic ir_to_update(input logic [3:0] op, output logic [3:0] cap);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 4; i++) begin
            cap[i] = tdo;
            step(i == 3, op[i]);
        end
        step(1, 0);
    endtask

    task automatic load_ir(input logic [3:0] op, output logic [3:0] cap);
        ir_to_update(op, cap);
        step(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            step(i == n - 1, din[i]);
        end
        step(1, 0); step(0, 0);
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'b0000:                   return "R4";
            4'b0010, 4'b0011:          return "R6";
            4'b0100:                   return "R7";
            4'b1001:                   return "R8";
            4'b1100:                   return "R9";
            4'b1101:                   return "R10";
            4'b1000, 4'b1010,
            4'b1011, 4'b1110:          return "R11";
            default:                   return "R5";
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [3:0]  cap;
        logic [63:0] dout;
        logic [63:0] exp;

        repeat (3) @(negedge tck);
        #1;
        // Reset state (R1, R12)
        check("R1 pin_mode after trst", pin_mode, 2'b00);
        check("R1 func_reset after trst", func_reset, 1'b0);
        check("R1 bsr_upd after trst", bsr_upd, '0);
        check("R12 tdo_en in reset", tdo_en, 1'b0);
        trst_n = 1'b1;
        step(0, 0);

        // Vector table walk over all sixteen opcodes
        for (int v = 0; v < 16; v++) begin
            logic [3:0] op;
            op = VEC[v][10:7];
            load_ir(op, cap);
            check({tag_of(op), " pin_mode"},  pin_mode,      VEC[v][4:3]);
            check({tag_of(op), " func_reset"}, func_reset,   VEC[v][2]);
            check({tag_of(op), " flash"},     flash_port_en, VEC[v][1]);
            check({tag_of(op), " forward"},   dbg_forward,   VEC[v][0]);
            scan_dr(40, 64'h1, dout);
            case (VEC[v][6:5])
                2'd0:    exp = {31'b0, 1'b1, ID_EXP};            // R4
                2'd2:    exp = {55'b0, 1'b1, CAP};               // R13
                default: exp = 64'h2;                            // R5
            endcase
            check({tag_of(op), " data register path"}, dout, exp);
        end

        // R2: capture pattern shifted out LSB first
        load_ir(4'b1111, cap);
        check("R2 IR capture bits", cap, 4'b0001);

        // R3: outputs change only when leaving Update-IR
        ir_to_update(4'b1001, cap);
        check("R3 func_reset held in Update-IR", func_reset, 1'b0);
        check("R3 pin_mode held in Update-IR", pin_mode, 2'b00);
        step(0, 0);
        check("R3 R8 func_reset after update", func_reset, 1'b1);
        check("R3 R8 pin_mode after update", pin_mode, 2'b10);
        scan_dr(4, 64'h0, dout);
        check("R3 override persists across DR scan", pin_mode, 2'b10);

        // R12: falling-edge output, enable only while shifting
        load_ir(4'b1111, cap);
        check("R12 tdo_en idle", tdo_en, 1'b0);
        step(1, 0); step(0, 0); step(0, 0);
        check("R12 tdo_en in Shift-DR", tdo_en, 1'b1);
        check("R12 captured bypass bit", tdo, 1'b0);
        tms = 1'b0; tdi = 1'b1;
        @(posedge tck); #1;
        check("R12 tdo stable after rising edge", tdo, 1'b0);
        @(negedge tck); #1;
        check("R12 tdo after falling edge", tdo, 1'b1);
        step(1, 0); step(1, 0); step(0, 0);
        check("R12 tdo_en after scan", tdo_en, 1'b0);

        // R6: preload, then sample-only leaves update stage alone
        load_ir(4'b0010, cap);
        scan_dr(8, 64'h5C, dout);
        check("R6 preload into update stage", bsr_upd, 8'h5C);
        check("R13 captured pins under preload", dout[7:0], CAP);
        load_ir(4'b0011, cap);
        scan_dr(8, 64'h33, dout);
        check("R6 sample-only keeps update stage", bsr_upd, 8'h5C);
        check("R13 captured pins under sample", dout[7:0], CAP);

        // R7: drive mode with preloaded values, then update while driving
        load_ir(4'b0100, cap);
        check("R7 drive mode", pin_mode, 2'b01);
        check("R7 preloaded values presented", bsr_upd, 8'h5C);
        scan_dr(8, 64'h81, dout);
        check("R7 update while driving", bsr_upd, 8'h81);
        check("R7 drive mode kept", pin_mode, 2'b01);
        check("R7 reset kept", func_reset, 1'b1);

        // R1: four high TMS edges from Shift-DR do not reset, five do
        step(1, 0); step(0, 0); step(0, 0);
        step(1, 0); step(1, 0); step(1, 0); step(1, 0);
        check("R1 override after four TMS highs", func_reset, 1'b1);
        step(1, 0);
        step(0, 0);
        check("R1 override cleared by TMS reset", func_reset, 1'b0);
        check("R1 pin mode cleared by TMS reset", pin_mode, 2'b00);
        scan_dr(32, 64'h0, dout);
        check("R1 R4 ident selected after TMS reset", dout[31:0], ID_EXP);

        // R1: asynchronous trst clears flash enable and update stage
        load_ir(4'b1101, cap);
        check("R10 flash enable", flash_port_en, 1'b1);
        trst_n = 1'b0;
        #1;
        check("R1 flash cleared by trst", flash_port_en, 1'b0);
        check("R1 update stage cleared by trst", bsr_upd, '0);
        @(negedge tck); #1;
        trst_n = 1'b1;
        step(0, 0);
        scan_dr(32, 64'h0, dout);
        check("R1 ident after trst", dout[31:0], ID_EXP);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule